// File: doc/BRIEF.md
# Edge-Triggered NMI Entry Sequencer

This block is the non-maskable interrupt front end of a small 8-bit CPU core. It passes the asynchronous, active-low interrupt pin through a synchronizer and compares each sample with the one before it. A falling transition sets a pending latch. The pending latch has no mask. No bit of the processor status can keep it from being serviced.

The core raises a one-cycle `poll` strobe at each instruction boundary. If a request is pending when the block sees the strobe, it takes a snapshot of the program counter, the status byte and the stack pointer, and then starts a fixed entry sequence. The sequence writes three bytes onto the stack page and reads the two vector bytes from the top of the address space. It then hands the core a new program counter and a new stack pointer, each with its own one-cycle load strobe. `busy` is high for the whole sequence so that the core stalls.

The state machine has seven states. IDLE goes to PUSH_PCH when `poll` is high and a request is pending (the "accept" transition). Otherwise IDLE stays where it is. From there the states follow a fixed chain, one cycle each: PUSH_PCH, PUSH_PCL, PUSH_PSR, VEC_LO, VEC_HI, LOAD_PC. LOAD_PC returns to IDLE (the "finish" transition).

Top module: `nmi_entry_seq`

## Requirements
- R1: After reset, `busy`, `mem_we`, `pc_load` and `sp_load` are low and nothing is pending, so a poll straight after reset starts no sequence.
- R2: Only a high-to-low transition of `nmi_n` makes a request pending. A rising transition does not.
- R3: Holding `nmi_n` low after its falling edge does not make a second request pending.
- R4: A pending request is acted on only in a cycle where `poll` is high. Without a poll it stays pending for any length of time and produces no bus activity.
- R5: The value of `status_in` has no effect on whether a pending request is serviced. An all-ones status byte is still serviced.
- R6: In the three cycles after the accepting poll, the block writes (`mem_we` high) the PC high byte to {8'h01, SP}, then the PC low byte to {8'h01, SP-1}, then the status byte to {8'h01, SP-2}. SP, PC and status are the values present at the accepting poll.
- R7: In the next two cycles the block reads address 16'hFFFA and then 16'hFFFB (`mem_we` low). Read data arrives one cycle after its address. In the following cycle `pc_load` and `sp_load` pulse together, with `pc_out` = {byte at 16'hFFFB, byte at 16'hFFFA} and `sp_out` = SP-3. After that `busy` falls.
- R8: Accepting a request clears the pending latch, so a later poll with no new falling edge starts nothing.
- R9: A falling edge that arrives while the sequence is running makes a request pending again, and the next poll after the sequence services it.
- R10: `poll` is ignored while `busy` is high. The running sequence is neither restarted nor extended.
- R11: The stack pointer wraps within the stack page. With SP = 8'h01 the writes go to 16'h0101, 16'h0100 and 16'h01FF, and `sp_out` is 8'hFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Active-low interrupt pin, asynchronous |
| poll | input | 1 | Instruction-boundary strobe from the core |
| pc_in | input | 16 | Return address, sampled at the accepting poll |
| status_in | input | 8 | Status byte, sampled at the accepting poll |
| sp_in | input | 8 | Stack pointer, sampled at the accepting poll |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Write enable; a read when low during `busy` |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| pc_out | output | 16 | Handler address |
| pc_load | output | 1 | One-cycle strobe to load `pc_out` |
| sp_out | output | 8 | Stack pointer after the three pushes |
| sp_load | output | 1 | One-cycle strobe to load `sp_out` |
| busy | output | 1 | High while the entry sequence runs |

## Verification
The assertions assume that the memory returns read data exactly one cycle after it sees an address. They also assume that `pc_in`, `status_in` and `sp_in` are valid in the cycle in which `poll` is sampled, and that `nmi_n` holds each level long enough to cross the synchronizer. The bench's memory model answers with a one-cycle registered read. The bench sets up all core inputs before it raises `poll`, and holds every `nmi_n` level for at least four clock cycles. One falling edge is deliberately placed inside a running sequence, and a poll is placed inside the busy window.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PUSH_PCH = 3'd1,
        ST_PUSH_PCL = 3'd2,
        ST_PUSH_PSR = 3'd3,
        ST_VEC_LO   = 3'd4,
        ST_VEC_HI   = 3'd5,
        ST_LOAD_PC  = 3'd6
    } nmi_state_e;

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clr,
    output logic pending
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    logic          fall;

    // Synchronizer chain; idle level of the pin is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[LAST-1:0], nmi_n};
            prev_q <= sync_q[LAST];
        end
    end

    assign fall = prev_q & ~sync_q[LAST];

    // A new edge wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (fall)
            pending <= 1'b1;
        else if (clr)
            pending <= 1'b0;
    end

endmodule

// File: rtl/nmi_entry_fsm.sv
module nmi_entry_fsm
    import nmi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [2*DATA_W-1:0] VECTOR_LO = 16'hFFFA
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  poll,
    input  logic                  pending,
    input  logic [2*DATA_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]     status_in,
    input  logic [DATA_W-1:0]     sp_in,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  mem_we,
    output logic [2*DATA_W-1:0]   pc_out,
    output logic                  pc_load,
    output logic [DATA_W-1:0]     sp_out,
    output logic                  sp_load,
    output logic                  busy,
    output logic                  clr_pending
);

    localparam int ADDR_W = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] VECTOR_HI = VECTOR_LO + ADDR_W'(1);

    nmi_state_e          state, state_nx;
    logic [ADDR_W-1:0]   pc_q;
    logic [DATA_W-1:0]   psr_q;
    logic [DATA_W-1:0]   sp_q;
    logic [DATA_W-1:0]   vec_lo_q;
    logic                accept;

    assign accept = (state == ST_IDLE) && poll && pending;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept) state_nx = ST_PUSH_PCH;
            ST_PUSH_PCH: state_nx = ST_PUSH_PCL;
            ST_PUSH_PCL: state_nx = ST_PUSH_PSR;
            ST_PUSH_PSR: state_nx = ST_VEC_LO;
            ST_VEC_LO:   state_nx = ST_VEC_HI;
            ST_VEC_HI:   state_nx = ST_LOAD_PC;
            ST_LOAD_PC:  state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Snapshot and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= '0;
            psr_q    <= '0;
            sp_q     <= '0;
            vec_lo_q <= '0;
        end else begin
            if (accept) begin
                pc_q  <= pc_in;
                psr_q <= status_in;
                sp_q  <= sp_in;
            end else if (mem_we) begin
                sp_q <= sp_q - DATA_W'(1);
            end
            if (state == ST_VEC_HI)
                vec_lo_q <= mem_rdata;
        end
    end

    // Outputs
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        pc_out    = {mem_rdata, vec_lo_q};
        pc_load   = 1'b0;
        sp_out    = sp_q;
        sp_load   = 1'b0;
        busy      = (state != ST_IDLE);
        clr_pending = accept;
        unique case (state)
            ST_IDLE: ;
            ST_PUSH_PCH: begin
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = pc_q[ADDR_W-1:DATA_W];
                mem_we    = 1'b1;
            end
            ST_PUSH_PCL: begin
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = pc_q[DATA_W-1:0];
                mem_we    = 1'b1;
            end
            ST_PUSH_PSR: begin
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = psr_q;
                mem_we    = 1'b1;
            end
            ST_VEC_LO:  mem_addr = VECTOR_LO;
            ST_VEC_HI:  mem_addr = VECTOR_HI;
            ST_LOAD_PC: begin
                pc_load = 1'b1;
                sp_load = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nmi_entry_seq.sv
module nmi_entry_seq #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0]   STACK_PAGE = 8'h01,
    parameter logic [2*DATA_W-1:0] VECTOR_LO  = 16'hFFFA
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nmi_n,
    input  logic                poll,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0]   status_in,
    input  logic [DATA_W-1:0]   sp_in,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_we,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [2*DATA_W-1:0] pc_out,
    output logic                pc_load,
    output logic [DATA_W-1:0]   sp_out,
    output logic                sp_load,
    output logic                busy
);

    logic pending;
    logic clr_pending;

    nmi_edge_latch #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n   (nmi_n),
        .clr     (clr_pending),
        .pending (pending)
    );

    nmi_entry_fsm #(
        .DATA_W     (DATA_W),
        .STACK_PAGE (STACK_PAGE),
        .VECTOR_LO  (VECTOR_LO)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll        (poll),
        .pending     (pending),
        .pc_in       (pc_in),
        .status_in   (status_in),
        .sp_in       (sp_in),
        .mem_rdata   (mem_rdata),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_we      (mem_we),
        .pc_out      (pc_out),
        .pc_load     (pc_load),
        .sp_out      (sp_out),
        .sp_load     (sp_load),
        .busy        (busy),
        .clr_pending (clr_pending)
    );

endmodule

// File: rtl/nmi_entry_seq_chk.sv
module nmi_entry_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                poll,
    input logic [2*DATA_W-1:0] pc_in,
    input logic [2*DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic                mem_we,
    input logic                pc_load,
    input logic                sp_load,
    input logic                busy
);

    // R1: no bus write outside the sequence
    p_we_in_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R4: a sequence starts only after a poll
    p_poll_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(poll));

    // R6: first write carries the PC high byte from the poll cycle
    p_first_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_we && mem_wdata == $past(pc_in[2*DATA_W-1:DATA_W])));

    // R6: pushes land in the stack page
    p_stack_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[2*DATA_W-1:DATA_W] == 8'h01));

    // R11: back-to-back pushes step down by one, wrapping in the page
    p_sp_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) - 8'd1));

    // R7: low vector read is followed by the high vector read
    p_vec_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we && mem_addr == 16'hFFFA) |=> (!mem_we && mem_addr == 16'hFFFB));

    // R7: PC and SP load together and the sequence then ends
    p_load_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> sp_load);

    p_load_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

endmodule

bind nmi_entry_seq nmi_entry_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll      (poll),
    .pc_in     (pc_in),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .pc_load   (pc_load),
    .sp_load   (sp_load),
    .busy      (busy)
);

// File: tb/nmi_entry_seq_test.sv
`timescale 1ns/1ps
module nmi_entry_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_n = 1'b1;
    logic        poll = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  status_in = '0;
    logic [7:0]  sp_in = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] pc_out;
    logic        pc_load;
    logic [7:0]  sp_out;
    logic        sp_load;
    logic        busy;

    logic [7:0]  vec_lo = 8'hEF;
    logic [7:0]  vec_hi = 8'hBE;

    int nchk = 0;
    int nfail = 0;

    logic [15:0] wa [8];
    logic [7:0]  wd [8];
    logic [15:0] ra [8];
    int          nwr = 0;
    int          nrd = 0;
    int          nload = 0;
    logic [15:0] got_pc = '0;
    logic [7:0]  got_sp = '0;

    always #5 clk = ~clk;

    nmi_entry_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_n     (nmi_n),
        .poll      (poll),
        .pc_in     (pc_in),
        .status_in (status_in),
        .sp_in     (sp_in),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .pc_out    (pc_out),
        .pc_load   (pc_load),
        .sp_out    (sp_out),
        .sp_load   (sp_load),
        .busy      (busy)
    );

    // Memory model: registered read, one cycle latency
    always @(posedge clk)
        mem_rdata <= (mem_addr == 16'hFFFA) ? vec_lo :
                     (mem_addr == 16'hFFFB) ? vec_hi : 8'h00;

    // Bus monitor sampling mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (nwr < 8) begin
                    wa[nwr] = mem_addr;
                    wd[nwr] = mem_wdata;
                end
                nwr = nwr + 1;
            end else if (busy && !pc_load) begin
                if (nrd < 8) ra[nrd] = mem_addr;
                nrd = nrd + 1;
            end
            if (pc_load) begin
                nload  = nload + 1;
                got_pc = pc_out;
                if (sp_load) got_sp = sp_out;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        nwr = 0; nrd = 0; nload = 0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_poll();
        @(negedge clk) poll = 1'b1;
        @(negedge clk) poll = 1'b0;
        wait_cyc(10);
    endtask

    task automatic nmi_pulse();
        @(negedge clk) nmi_n = 1'b1;
        wait_cyc(4);
        nmi_n = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 1'b0);
        chk("R1 we", mem_we, 1'b0);
        chk("R1 pc_load", pc_load, 1'b0);
        chk("R1 sp_load", sp_load, 1'b0);
        clear_logs();
        do_poll();
        chk("R1 no entry after reset", nload, 0);
        chk("R1 no writes after reset", nwr, 0);
    endtask

    task automatic t_basic();
        pc_in = 16'h1234; status_in = 8'hA5; sp_in = 8'hFD;
        clear_logs();
        nmi_pulse();
        do_poll();
        chk("R6 write count", nwr, 3);
        chk("R6 addr0", wa[0], 16'h01FD);
        chk("R6 data0", wd[0], 8'h12);
        chk("R6 addr1", wa[1], 16'h01FC);
        chk("R6 data1", wd[1], 8'h34);
        chk("R6 addr2", wa[2], 16'h01FB);
        chk("R6 data2", wd[2], 8'hA5);
        chk("R7 read count", nrd, 2);
        chk("R7 read0", ra[0], 16'hFFFA);
        chk("R7 read1", ra[1], 16'hFFFB);
        chk("R7 loads", nload, 1);
        chk("R7 pc_out", got_pc, 16'hBEEF);
        chk("R7 sp_out", got_sp, 8'hFA);
        chk("R7 busy low", busy, 1'b0);
    endtask

    task automatic t_held_low();
        clear_logs();
        do_poll();
        chk("R8 cleared after entry", nload, 0);
        wait_cyc(20);
        do_poll();
        chk("R3 held low no re-arm", nload, 0);
        @(negedge clk) nmi_n = 1'b1;
        wait_cyc(5);
        do_poll();
        chk("R2 rising edge ignored", nload, 0);
        chk("R2 no writes", nwr, 0);
    endtask

    task automatic t_no_poll();
        pc_in = 16'h5A3C; status_in = 8'hFF; sp_in = 8'hF0;
        clear_logs();
        nmi_pulse();
        wait_cyc(50);
        chk("R4 no writes without poll", nwr, 0);
        chk("R4 idle without poll", busy, 1'b0);
        do_poll();
        chk("R5 serviced with status all ones", nload, 1);
        chk("R5 status pushed", wd[2], 8'hFF);
        chk("R4 late poll pc", got_pc, 16'hBEEF);
    endtask

    task automatic t_rearm();
        pc_in = 16'h0800; status_in = 8'h24; sp_in = 8'h80;
        clear_logs();
        nmi_pulse();
        @(negedge clk) nmi_n = 1'b1;
        wait_cyc(4);
        poll = 1'b1;
        @(negedge clk) poll = 1'b0;
        @(negedge clk) begin
            nmi_n = 1'b0;
            poll  = 1'b1;
            chk("R10 busy during sequence", busy, 1'b1);
        end
        @(negedge clk) poll = 1'b0;
        wait_cyc(12);
        chk("R10 single entry", nload, 1);
        chk("R10 three writes", nwr, 3);
        do_poll();
        chk("R9 re-armed entry", nload, 2);
        chk("R9 second writes", nwr, 6);
    endtask

    task automatic t_wrap();
        pc_in = 16'hABCD; status_in = 8'h3C; sp_in = 8'h01;
        vec_lo = 8'h34; vec_hi = 8'hC2;
        clear_logs();
        nmi_pulse();
        do_poll();
        chk("R11 addr0", wa[0], 16'h0101);
        chk("R11 addr1", wa[1], 16'h0100);
        chk("R11 addr2", wa[2], 16'h01FF);
        chk("R11 sp_out", got_sp, 8'hFE);
        chk("R7 pc_out new vector", got_pc, 16'hC234);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_held_low();
        t_no_poll();
        t_rearm();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #1000000;
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule